// File: doc/BRIEF.md
# Uncorrectable Error Header Log with Multi-Record Queue

This block holds the logging state that goes with uncorrectable errors: a
status register with write-one-to-clear bits, a pointer to the first error,
and a header log and a prefix log captured from that error. A second error can
arrive while software has not yet serviced the first one. When multi-recording
is switched on, that later error is kept in an ordered queue and does not
overwrite the log.

Software services an error by writing a one to the status bit that the
pointer selects. That write moves the oldest queued record into the log. It
also sets again the status bits of every record still waiting, so the next
pointer always selects a bit that is set. The block does not decode
configuration space, classify severity or route messages. It receives
already-classified error events and a decoded write strobe.

Top module: `uerr_hdr_log_q`

## Requirements
- R1: After a synchronous active-low reset, the pointer, the status register, both logs, the prefix-present flag and the overflow pulse are zero, and the queue is empty.
- R2: An event is accepted only if exactly one bit of its status is set. An accepted event sets that bit in the status register. An event with no bit set, or with more than one, changes nothing.
- R3: An accepted event that is not queued is loaded into the log. The pointer becomes the position of its status bit, with bit 0 giving pointer 0.
- R4: When a record is loaded, the header log takes its four dwords if its header-valid flag is set and is zero otherwise. The prefix log takes its four dwords, and the prefix-present flag is set, only when the record's prefix flag and the prefix-support input are both high. Otherwise both are zero. Dword k occupies bits [32k+31:32k] of each log.
- R5: If multi-recording is active and the status bit at the pointer is set, an accepted event is appended to the tail of the queue and the log is left unchanged.
- R6: An append to a queue that already holds the maximum depth of records drops the event, although its status bit is still set. The overflow output is then high for exactly the one cycle after that event.
- R7: A write that clears the status bit at the pointer, while multi-recording is active and the queue is not empty, sets the status bit of every queued record again. It then loads the oldest record into the log and removes it, so records leave in arrival order.
- R8: A write that clears the status bit at the pointer, while multi-recording is off or the queue is empty, sets the pointer, the prefix-present flag and both logs to zero.
- R9: A write that leaves the status bit at the pointer set, while multi-recording is active, sets the status bits of all queued records again. Clears to any other bit take effect.
- R10: A write that leaves the status bit at the pointer set, while multi-recording is off, discards the whole queue.
- R11: All updates appear on the outputs one clock after the triggering input. An event in the same cycle as a write is handled after the write.
- R12: Multi-recording is active only when the enable input is high and the depth parameter is nonzero. The capability output is 1 exactly when the depth is nonzero. With depth 0 every accepted event overwrites the log.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Error event strobe |
| ev_status | input | 32 | Event status, one-hot |
| ev_hdr | input | 128 | Event header, four dwords |
| ev_pfx | input | 128 | Event prefix, four dwords |
| ev_hdr_vld | input | 1 | Header dwords are meaningful |
| ev_pfx_vld | input | 1 | Prefix dwords are present |
| pfx_en | input | 1 | Prefix logging supported |
| mhr_en | input | 1 | Multi-recording enable |
| wr_valid | input | 1 | Status register write strobe |
| wr_data | input | 32 | Write-one-to-clear data |
| fep | output | 5 | First-error pointer |
| pfx_present | output | 1 | Prefix log holds data |
| hdr_log | output | 128 | Header log |
| pfx_log | output | 128 | Prefix log |
| unc_status | output | 32 | Uncorrectable status register |
| mhr_cap | output | 1 | Multi-recording capability |
| ovf | output | 1 | Queue overflow pulse |

## Verification
The main instance is built with a queue depth of 3. Overflow, a pop and an
append in the same cycle, and pops while the queue is full can then all be
reached within a handful of events. A second instance with depth 0 shares the
same stimulus. It shows that the capability bit reads zero and that later
events overwrite the log even with the enable high. A long stretch of mixed
events and clear writes aims its writes at the current pointer. This drains,
refills and flushes the queue many times against the cycle-level model.

// File: rtl/uerr_log_pkg.sv
// Shared record format and helpers for the uncorrectable error log.
// Assumes 32 status bits and four-dword header and prefix captures.
package uerr_log_pkg;

    localparam int STAT_W  = 32;
    localparam int IDX_W   = $clog2(STAT_W);
    localparam int DWORD_W = 32;
    localparam int HDR_DW  = 4;
    localparam int PFX_DW  = 4;
    localparam int HDR_W   = HDR_DW * DWORD_W;
    localparam int PFX_W   = PFX_DW * DWORD_W;

    // One logged or queued error.
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             hdr_ok;
        logic             pfx_ok;
        logic [HDR_W-1:0] hdr;
        logic [PFX_W-1:0] pfx;
    } err_rec_t;

    // True when exactly one bit of the vector is set.
    function automatic logic is_single(input logic [STAT_W-1:0] v);
        return (v != '0) && ((v & (v - STAT_W'(1))) == '0);
    endfunction

endpackage

// File: rtl/uerr_bit_index.sv
// Encodes a one-hot vector into the index of its set bit.
// Assumes at most one bit is set; several set bits give an OR of indices.
module uerr_bit_index #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  onehot,
    output logic [IW-1:0] idx
);

    // Mask of the input positions whose index has bit k set.
    function automatic logic [W-1:0] pos_mask(input int k);
        logic [W-1:0] m;
        m = '0;
        for (int b = 0; b < W; b++) begin
            m[b] = ((b >> k) & 1) == 1;
        end
        return m;
    endfunction

    for (genvar k = 0; k < IW; k++) begin : g_bit
        localparam logic [W-1:0] MASK = pos_mask(k);
        assign idx[k] = |(onehot & MASK);
    end

endmodule

// File: rtl/uerr_rec_queue.sv
// Ordered record queue in shift form: slot 0 is always the oldest record.
// Supports push, pop and flush. A push and a pop in the same cycle are
// legal; the caller must not push when the queue would be full after the pop.
// Also reports the OR of the decoded status bits of all held records.
module uerr_rec_queue
    import uerr_log_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = (DEPTH < 1) ? 1 : $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              pop,
    input  logic              push,
    input  err_rec_t          din,
    output err_rec_t          head,
    output logic [CW-1:0]     count,
    output logic [STAT_W-1:0] held_bits
);

    if (DEPTH == 0) begin : g_none
        assign head      = '0;
        assign count     = '0;
        assign held_bits = '0;
    end else begin : g_fifo
        err_rec_t          slot [DEPTH];
        logic [CW-1:0]     cnt;
        logic [CW-1:0]     widx;
        logic [STAT_W-1:0] slot_bits [DEPTH];

        // Write position: the first free slot after any pop this cycle.
        assign widx = pop ? (cnt - CW'(1)) : cnt;

        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            // Slot storage: take new data, or shift one place toward the head.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot[i] <= '0;
                end else if (push && (widx == CW'(i))) begin
                    slot[i] <= din;
                end else if (pop) begin
                    if (i < DEPTH - 1) begin
                        slot[i] <= slot[(i < DEPTH - 1) ? i + 1 : i];
                    end
                end
            end

            // Decoded status bit of this slot, zero when the slot is empty.
            assign slot_bits[i] = (CW'(i) < cnt) ? (STAT_W'(1) << slot[i].idx) : '0;
        end

        // Occupancy counter.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + CW'(push) - CW'(pop);
            end
        end

        // Union of the status bits held in the queue.
        always_comb begin
            held_bits = '0;
            for (int i = 0; i < DEPTH; i++) begin
                held_bits = held_bits | slot_bits[i];
            end
        end

        assign head  = slot[0];
        assign count = cnt;
    end

endmodule

// File: rtl/uerr_log_bank.sv
// Holds the log: first-error pointer, header log, prefix log and the
// prefix-present flag. A load takes priority over a clear.
// Assumes the caller asserts at most one load per cycle.
module uerr_log_bank
    import uerr_log_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld,
    input  err_rec_t         rec,
    input  logic             pfx_en,
    output logic [IDX_W-1:0] fep,
    output logic             pfx_present,
    output logic [HDR_W-1:0] hdr_log,
    output logic [PFX_W-1:0] pfx_log
);

    logic pfx_take;

    // The prefix is kept only when the record carries one and support is on.
    assign pfx_take = rec.pfx_ok && pfx_en;

    // Log registers: load a record, clear, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fep         <= '0;
            pfx_present <= 1'b0;
            hdr_log     <= '0;
            pfx_log     <= '0;
        end else if (ld) begin
            fep         <= rec.idx;
            pfx_present <= pfx_take;
            hdr_log     <= rec.hdr_ok ? rec.hdr : '0;
            pfx_log     <= pfx_take ? rec.pfx : '0;
        end else if (clr) begin
            fep         <= '0;
            pfx_present <= 1'b0;
            hdr_log     <= '0;
            pfx_log     <= '0;
        end
    end

endmodule

// File: rtl/uerr_hdr_log_q.sv
// Uncorrectable error header log with a multi-record queue.
// Each cycle, a status write is applied first, then an error event.
// Assumes the write strobe already carries write-one-to-clear data
// for the status register, and that events come pre-classified.
module uerr_hdr_log_q
    import uerr_log_pkg::*;
#(
    parameter int Q_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [STAT_W-1:0] ev_status,
    input  logic [HDR_W-1:0]  ev_hdr,
    input  logic [PFX_W-1:0]  ev_pfx,
    input  logic              ev_hdr_vld,
    input  logic              ev_pfx_vld,
    input  logic              pfx_en,
    input  logic              mhr_en,
    input  logic              wr_valid,
    input  logic [STAT_W-1:0] wr_data,
    output logic [IDX_W-1:0]  fep,
    output logic              pfx_present,
    output logic [HDR_W-1:0]  hdr_log,
    output logic [PFX_W-1:0]  pfx_log,
    output logic [STAT_W-1:0] unc_status,
    output logic              mhr_cap,
    output logic              ovf
);

    localparam int            CW   = (Q_DEPTH < 1) ? 1 : $clog2(Q_DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(Q_DEPTH);

    logic              mhr_on;
    logic [IDX_W-1:0]  ev_idx;
    err_rec_t          ev_rec;
    err_rec_t          q_head;
    logic [CW-1:0]     q_count;
    logic [STAT_W-1:0] q_bits;
    logic [STAT_W-1:0] stat_cl;
    logic [STAT_W-1:0] stat_mid;
    logic [STAT_W-1:0] stat_nxt;
    logic [IDX_W-1:0]  fep_mid;
    logic [CW-1:0]     cnt_mid;
    logic              ev_ok;
    logic              do_pop;
    logic              do_flush;
    logic              do_clr;
    logic              do_push;
    logic              do_drop;
    logic              ev_load;

    assign mhr_cap = (Q_DEPTH > 0);
    assign mhr_on  = mhr_cap && mhr_en;
    assign ev_ok   = ev_valid && is_single(ev_status);

    uerr_bit_index #(.W(STAT_W), .IW(IDX_W)) u_idx (
        .onehot (ev_status),
        .idx    (ev_idx)
    );

    // Pack the incoming event as a record.
    always_comb begin
        ev_rec.idx    = ev_idx;
        ev_rec.hdr_ok = ev_hdr_vld;
        ev_rec.pfx_ok = ev_pfx_vld;
        ev_rec.hdr    = ev_hdr;
        ev_rec.pfx    = ev_pfx;
    end

    // Write phase: apply clears, then pick pop, flush, log clear or re-assert.
    always_comb begin
        stat_cl  = wr_valid ? (unc_status & ~wr_data) : unc_status;
        stat_mid = stat_cl;
        do_pop   = 1'b0;
        do_flush = 1'b0;
        do_clr   = 1'b0;
        if (wr_valid) begin
            if (!stat_cl[fep]) begin
                if (!mhr_on || (q_count == '0)) begin
                    do_clr = 1'b1;
                end else begin
                    stat_mid = stat_cl | q_bits;
                    do_pop   = 1'b1;
                end
            end else if (mhr_on) begin
                stat_mid = stat_cl | q_bits;
            end else begin
                do_flush = 1'b1;
            end
        end
    end

    // Event phase: queue, drop or load, using the state after the write.
    always_comb begin
        fep_mid = do_pop ? q_head.idx : (do_clr ? '0 : fep);
        cnt_mid = q_count - CW'(do_pop);
        do_push = 1'b0;
        do_drop = 1'b0;
        ev_load = 1'b0;
        if (ev_ok) begin
            if (mhr_on && stat_mid[fep_mid]) begin
                if (cnt_mid == FULL) begin
                    do_drop = 1'b1;
                end else begin
                    do_push = 1'b1;
                end
            end else begin
                ev_load = 1'b1;
            end
        end
        stat_nxt = stat_mid | (ev_ok ? ev_status : '0);
    end

    uerr_rec_queue #(.DEPTH(Q_DEPTH), .CW(CW)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (do_flush),
        .pop       (do_pop),
        .push      (do_push),
        .din       (ev_rec),
        .head      (q_head),
        .count     (q_count),
        .held_bits (q_bits)
    );

    uerr_log_bank u_log (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (do_clr),
        .ld          (ev_load || do_pop),
        .rec         (ev_load ? ev_rec : q_head),
        .pfx_en      (pfx_en),
        .fep         (fep),
        .pfx_present (pfx_present),
        .hdr_log     (hdr_log),
        .pfx_log     (pfx_log)
    );

    // Status register and overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unc_status <= '0;
            ovf        <= 1'b0;
        end else begin
            unc_status <= stat_nxt;
            ovf        <= do_drop;
        end
    end

endmodule

// File: rtl/uerr_hdr_log_q_chk.sv
// Property checker for uerr_hdr_log_q, attached by bind.
// Observes ports and the queue occupancy only.
module uerr_hdr_log_q_chk
    import uerr_log_pkg::*;
#(
    parameter int Q_DEPTH = 8,
    parameter int CW      = (Q_DEPTH < 1) ? 1 : $clog2(Q_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic [STAT_W-1:0] ev_status,
    input logic              wr_valid,
    input logic [STAT_W-1:0] wr_data,
    input logic              mhr_en,
    input logic [IDX_W-1:0]  fep,
    input logic [STAT_W-1:0] unc_status,
    input logic              pfx_present,
    input logic [PFX_W-1:0]  pfx_log,
    input logic              ovf,
    input logic [CW-1:0]     q_count
);

    assert_event_sets_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && is_single(ev_status)) |=> ((unc_status & $past(ev_status)) != '0));

    assert_no_prefix_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pfx_present |-> (pfx_log == '0));

    assert_ovf_after_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> $past(ev_valid));

    assert_depth_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CW'(Q_DEPTH));

    assert_flush_queue_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !mhr_en && (((unc_status & ~wr_data) >> fep) & 32'd1) != '0)
        |=> (q_count == '0));

    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid && !ev_valid) |=> ($stable(unc_status) && $stable(fep)));

endmodule

bind uerr_hdr_log_q uerr_hdr_log_q_chk #(.Q_DEPTH(Q_DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_valid    (ev_valid),
    .ev_status   (ev_status),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .mhr_en      (mhr_en),
    .fep         (fep),
    .unc_status  (unc_status),
    .pfx_present (pfx_present),
    .pfx_log     (pfx_log),
    .ovf         (ovf),
    .q_count     (q_count)
);

// File: tb/tb_uerr_hdr_log_q.sv
module tb_uerr_hdr_log_q;
    import uerr_log_pkg::*;

    localparam int QD = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              ev_valid = 1'b0;
    logic [STAT_W-1:0] ev_status = '0;
    logic [HDR_W-1:0]  ev_hdr = '0;
    logic [PFX_W-1:0]  ev_pfx = '0;
    logic              ev_hdr_vld = 1'b0;
    logic              ev_pfx_vld = 1'b0;
    logic              pfx_en = 1'b1;
    logic              mhr_en = 1'b1;
    logic              wr_valid = 1'b0;
    logic [STAT_W-1:0] wr_data = '0;

    logic [IDX_W-1:0]  fep, z_fep;
    logic              pp, z_pp;
    logic [HDR_W-1:0]  hdr_log, z_hdr;
    logic [PFX_W-1:0]  pfx_log, z_pfx;
    logic [STAT_W-1:0] st, z_st;
    logic              cap, z_cap;
    logic              ovf, z_ovf;

    uerr_hdr_log_q #(.Q_DEPTH(QD)) dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_status(ev_status),
        .ev_hdr(ev_hdr), .ev_pfx(ev_pfx), .ev_hdr_vld(ev_hdr_vld),
        .ev_pfx_vld(ev_pfx_vld), .pfx_en(pfx_en), .mhr_en(mhr_en),
        .wr_valid(wr_valid), .wr_data(wr_data), .fep(fep), .pfx_present(pp),
        .hdr_log(hdr_log), .pfx_log(pfx_log), .unc_status(st),
        .mhr_cap(cap), .ovf(ovf));

    uerr_hdr_log_q #(.Q_DEPTH(0)) dut0 (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_status(ev_status),
        .ev_hdr(ev_hdr), .ev_pfx(ev_pfx), .ev_hdr_vld(ev_hdr_vld),
        .ev_pfx_vld(ev_pfx_vld), .pfx_en(pfx_en), .mhr_en(mhr_en),
        .wr_valid(wr_valid), .wr_data(wr_data), .fep(z_fep), .pfx_present(z_pp),
        .hdr_log(z_hdr), .pfx_log(z_pfx), .unc_status(z_st),
        .mhr_cap(z_cap), .ovf(z_ovf));

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct {
        int               idx;
        bit               hv;
        bit               pv;
        logic [HDR_W-1:0] h;
        logic [PFX_W-1:0] p;
    } ent_t;

    ent_t              mq[$];
    logic [STAT_W-1:0] m_st  = '0;
    int                m_fep = 0;
    bit                m_pp  = 0;
    logic [HDR_W-1:0]  m_hdr = '0;
    logic [PFX_W-1:0]  m_pfx = '0;
    bit                m_ovf = 0;

    task automatic m_load(input ent_t e);
        m_fep = e.idx;
        m_hdr = e.hv ? e.h : '0;
        m_pp  = e.pv && pfx_en;
        m_pfx = m_pp ? e.p : '0;
    endtask

    task automatic m_clear();
        m_fep = 0; m_pp = 0; m_hdr = '0; m_pfx = '0;
    endtask

    always @(posedge clk) begin : model
        bit   mhr;
        ent_t e;
        mhr = mhr_en && (QD > 0);
        if (!rst_n) begin
            m_st = '0; m_ovf = 0; mq.delete(); m_clear();
        end else begin
            m_ovf = 0;
            if (wr_valid) begin
                m_st = m_st & ~wr_data;
                if (!m_st[m_fep]) begin
                    if (!mhr || mq.size() == 0) m_clear();
                    else begin
                        foreach (mq[i]) m_st[mq[i].idx] = 1'b1;
                        e = mq.pop_front();
                        m_load(e);
                    end
                end else if (mhr) begin
                    foreach (mq[i]) m_st[mq[i].idx] = 1'b1;
                end else begin
                    mq.delete();
                end
            end
            if (ev_valid && $countones(ev_status) == 1) begin
                e.idx = 0;
                for (int b = 0; b < STAT_W; b++) if (ev_status[b]) e.idx = b;
                e.hv = ev_hdr_vld; e.pv = ev_pfx_vld; e.h = ev_hdr; e.p = ev_pfx;
                if (mhr && m_st[m_fep]) begin
                    if (mq.size() == QD) m_ovf = 1;
                    else mq.push_back(e);
                end else begin
                    m_load(e);
                end
                m_st = m_st | ev_status;
            end
        end
    end

    // One clock: inputs already set, sample at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk("R2 status", 128'(st), 128'(m_st));
        chk("R3 pointer", 128'(fep), 128'(m_fep));
        chk("R4 header log", hdr_log, m_hdr);
        chk("R4 prefix log", {pfx_log[126:0], pp}, {m_pfx[126:0], m_pp});
        chk("R6 overflow", 128'(ovf), 128'(m_ovf));
        chk("R6 prefix top bit", 128'(pfx_log[127]), 128'(m_pfx[127]));
    endtask

    task automatic idle();
        ev_valid = 0; wr_valid = 0; wr_data = '0;
    endtask

    task automatic event_in(input int b, input bit hv, input bit pv,
                            input logic [HDR_W-1:0] h, input logic [PFX_W-1:0] p);
        ev_valid = 1; ev_status = STAT_W'(1) << b;
        ev_hdr_vld = hv; ev_pfx_vld = pv; ev_hdr = h; ev_pfx = p;
    endtask

    localparam logic [HDR_W-1:0] H1 = 128'h11110004_22220004_33330004_44440004;
    localparam logic [PFX_W-1:0] P1 = 128'hAAAA0004_BBBB0004_CCCC0004_DDDD0004;
    localparam logic [HDR_W-1:0] H2 = 128'h11110009_22220009_33330009_44440009;
    localparam logic [HDR_W-1:0] H3 = 128'h1111000C_2222000C_3333000C_4444000C;
    localparam logic [HDR_W-1:0] H4 = 128'h11110014_22220014_33330014_44440014;

    initial begin
        @(negedge clk);
        idle();
        repeat (3) step();
        rst_n = 1;
        step();
        chk("R1 reset pointer", 128'(fep), 128'd0);
        chk("R1 reset status", 128'(st), 128'd0);
        chk("R1 reset header", hdr_log, '0);
        chk("R1 reset overflow", 128'(ovf), 128'd0);
        chk("R12 capability depth3", 128'(cap), 128'd1);
        chk("R12 capability depth0", 128'(z_cap), 128'd0);

        // R2: malformed events change nothing
        ev_valid = 1; ev_status = '0; step();
        ev_status = 32'h6; step();
        idle();
        chk("R2 ignored malformed", 128'(st), 128'd0);

        // R3/R4: first error
        event_in(4, 1, 1, H1, P1); step(); idle();
        chk("R3 first pointer", 128'(fep), 128'd4);
        chk("R4 header stored", hdr_log, H1);
        chk("R4 prefix stored", pfx_log, P1);
        chk("R4 prefix flag", 128'(pp), 128'd1);

        // R5: queued, log unchanged
        event_in(7, 0, 0, H2, P1); step(); idle();
        chk("R5 log kept pointer", 128'(fep), 128'd4);
        chk("R5 log kept header", hdr_log, H1);

        // R6: fill and overflow
        event_in(9, 1, 0, H2, '0); step();
        event_in(12, 1, 0, H3, '0); step();
        event_in(15, 1, 0, H4, '0); step(); idle();
        chk("R6 overflow pulse", 128'(ovf), 128'd1);
        chk("R6 dropped bit set", 128'(st), 128'h9290);
        chk("R12 depth0 overwrites", 128'(z_fep), 128'd15);
        chk("R12 depth0 no overflow", 128'(z_ovf), 128'd0);
        step();
        chk("R6 pulse one cycle", 128'(ovf), 128'd0);

        // R7: pop oldest, re-assert queued bits
        wr_valid = 1; wr_data = 32'h210; step(); idle();
        chk("R7 popped pointer", 128'(fep), 128'd7);
        chk("R7 popped header zero", hdr_log, '0);
        chk("R7 reasserted status", 128'(st), 128'h9280);

        // R9: other clears undone only for queued bits
        wr_valid = 1; wr_data = 32'h9000; step(); idle();
        chk("R9 status", 128'(st), 128'h1280);
        chk("R9 pointer", 128'(fep), 128'd7);

        // R11: write then event in one cycle
        wr_valid = 1; wr_data = 32'h80; event_in(20, 1, 0, H4, '0); step(); idle();
        chk("R11 pointer after pop", 128'(fep), 128'd9);
        chk("R11 header after pop", hdr_log, H2);
        chk("R11 status", 128'(st), 128'h101200);

        // R10/R8: flush with multi-recording off, then clear
        mhr_en = 0; wr_valid = 1; wr_data = 32'h1000; step();
        chk("R10 status after flush", 128'(st), 128'h100200);
        wr_data = 32'h200; step();
        chk("R8 pointer cleared", 128'(fep), 128'd0);
        chk("R8 header cleared", hdr_log, '0);
        mhr_en = 1; wr_data = 32'h0; step(); idle();
        chk("R10 queue discarded", 128'(fep), 128'd0);
        chk("R10 status kept", 128'(st), 128'h100000);

        // R4: prefix support off
        pfx_en = 0; event_in(3, 1, 1, H1, P1); step(); idle(); pfx_en = 1;
        chk("R4 no prefix support flag", 128'(pp), 128'd0);
        chk("R4 no prefix support log", pfx_log, '0);
        chk("R4 header with prefix off", hdr_log, H1);

        // Mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom % 16;
            ev_valid = (r < 9);
            ev_status = (r == 0) ? $urandom : (STAT_W'(1) << ($urandom % STAT_W));
            ev_hdr = {$urandom, $urandom, $urandom, $urandom};
            ev_pfx = {$urandom, $urandom, $urandom, $urandom};
            ev_hdr_vld = $urandom % 2;
            ev_pfx_vld = $urandom % 2;
            pfx_en = ($urandom % 4) != 0;
            if (($urandom % 64) == 0) mhr_en = ~mhr_en;
            r = $urandom % 8;
            wr_valid = (r < 3);
            wr_data = (r == 0) ? (STAT_W'(1) << m_fep)
                    : (r == 1) ? ($urandom & $urandom) | (STAT_W'(1) << m_fep)
                    : ($urandom & $urandom & $urandom);
            step();
        end
        idle();
        step();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule